// File: doc/BRIEF.md
# Reloadable Gated-Count Timer with Pulse-Width Output

This block is a 16-bit up-counter that starts from a programmable reload value and counts up to all-ones. On the step that would wrap it to zero, it reloads the start value and raises a one-cycle timeout pulse. Each count step needs two conditions at once. The first comes from a group of fast sources or a constant, and the second from a group of slow sources or a constant. A 4-bit select code picks both, so either input can throttle the timer or stop it. All candidate sources arrive as single-cycle enable pulses in the system clock domain.

Every timeout also advances a 256-slot pulse-width generator. Its output is high for the first `duty` slots of each 256-timeout period. Duty codes that are out of range are pulled back to the nearest legal value.

Software-style inputs set the reload register, load it into the counter, pick the sources and set the duty. The reload register and the live count are visible at the outputs.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset the count is 0, the reload register is 0, the timeout pulse is low and the PWM output is high, because the slot is 0 and the clamped duty is at least 1.
- R2: A cycle with `reload_wr` high stores `reload_din`, and the stored value appears on `reload_q` after that edge.
- R3: A cycle with `cnt_wr` high copies the reload register into the counter. If `reload_wr` is high in the same cycle, the value copied is the one held before that write.
- R4: The count enable is the AND of input A and input B. Each enabled cycle below 0xFFFF adds one to the count, and a cycle that is not enabled leaves the count unchanged.
- R5: An enabled cycle at 0xFFFF loads the reload value and drives `tmo` high for exactly that one following cycle.
- R6: Select code 0000 forces both inputs to 0, so the count holds whatever pulses arrive.
- R7: When `clk_sel[3:2]` is 00, input A is constant 0 and the timer is stopped for every setting of `clk_sel[1:0]`.
- R8: When `clk_sel[3:2]` is 11, input A is constant 1 and input B alone sets the count rate.
- R9: Input A is chosen by `clk_sel[3:2]`: 00 gives 0, 01 gives `src_fast`, 10 gives `src_ext` and 11 gives 1. Input B is chosen by `clk_sel[1:0]`: 00 gives 1, 01 gives `src_64hz`, 10 gives `src_16hz` and 11 gives `src_2hz`.
- R10: A slot counter, reset to 0, advances by one modulo 256 on every timeout. `pwm_out` is high while the slot is below the effective duty, so each 256-timeout period is high for exactly the effective duty.
- R11: A duty code of 0 acts as 1 and a code of 255 acts as 254. Codes 1 to 254 are used unchanged.
- R12: A `cnt_wr` in the same cycle as a wrap takes priority: the counter loads the reload value and no timeout pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_din | input | 16 | Value for the reload register |
| reload_wr | input | 1 | Write strobe for the reload register |
| cnt_wr | input | 1 | Strobe that copies the reload register into the counter |
| clk_sel | input | 4 | Source select: [3:2] chooses input A, [1:0] chooses input B |
| duty_code | input | 8 | PWM high time in timeouts per 256 |
| src_fast | input | 1 | Fast enable pulse |
| src_ext | input | 1 | External enable pulse |
| src_64hz | input | 1 | 64 Hz enable pulse |
| src_16hz | input | 1 | 16 Hz enable pulse |
| src_2hz | input | 1 | 2 Hz enable pulse |
| reload_q | output | 16 | Reload register read-back |
| count_q | output | 16 | Current count |
| tmo | output | 1 | One-cycle timeout pulse |
| pwm_out | output | 1 | Pulse-width output level |

## Verification
The hardest case to reach is a full 256-slot PWM period, together with the duty clamps at its ends. Each slot normally needs 64K enabled counts. The stimulus avoids this by setting the reload to 0xFFFF or 0xFFFE with both inputs constant 1, so a timeout happens every one or two cycles, and then counts the high samples across a whole period. The same all-ones reload holds the counter at the wrap value, which makes it possible to land a counter write exactly on a wrap cycle. The source pulses repeat with periods of 3, 4, 5, 7 and 11 cycles, so pairs of gated inputs coincide only now and then. A cycle-accurate reference model follows every select code through these sparse coincidences.

// File: rtl/gated_reload_timer.sv
module gated_reload_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] reload_din,
  input  logic          reload_wr,
  input  logic          cnt_wr,
  input  logic [3:0]    clk_sel,
  input  logic [PW-1:0] duty_code,
  input  logic          src_fast,
  input  logic          src_ext,
  input  logic          src_64hz,
  input  logic          src_16hz,
  input  logic          src_2hz,
  output logic [CW-1:0] reload_q,
  output logic [CW-1:0] count_q,
  output logic          tmo,
  output logic          pwm_out
);
  localparam logic [CW-1:0] CNT_TOP  = '1;
  localparam logic [PW-1:0] DUTY_MAX = {{(PW-1){1'b1}}, 1'b0};
  localparam logic [PW-1:0] DUTY_MIN = {{(PW-1){1'b0}}, 1'b1};

  logic          in_a, in_b, cnt_en, at_top;
  logic [PW-1:0] slot_q, duty_eff;

  always_comb begin
    case (clk_sel[3:2])
      2'b00:   in_a = 1'b0;
      2'b01:   in_a = src_fast;
      2'b10:   in_a = src_ext;
      default: in_a = 1'b1;
    endcase
    if (clk_sel == 4'b0000) in_b = 1'b0;
    else begin
      case (clk_sel[1:0])
        2'b00:   in_b = 1'b1;
        2'b01:   in_b = src_64hz;
        2'b10:   in_b = src_16hz;
        default: in_b = src_2hz;
      endcase
    end
  end

  assign cnt_en = in_a & in_b;
  assign at_top = (count_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) reload_q <= '0;
    else if (reload_wr) reload_q <= reload_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      tmo     <= 1'b0;
      slot_q  <= '0;
    end else begin
      tmo <= 1'b0;
      if (cnt_wr) count_q <= reload_q;
      else if (cnt_en) begin
        if (at_top) begin
          count_q <= reload_q;
          tmo     <= 1'b1;
          slot_q  <= slot_q + 1'b1;
        end else begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (duty_code == '0) duty_eff = DUTY_MIN;
    else if (duty_code == '1) duty_eff = DUTY_MAX;
    else duty_eff = duty_code;
  end

  assign pwm_out = (slot_q < duty_eff);
endmodule

// File: rtl/grt_checker.sv
module grt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reload_wr,
  input logic [CW-1:0] reload_din,
  input logic          cnt_wr,
  input logic [3:0]    clk_sel,
  input logic [CW-1:0] reload_q,
  input logic [CW-1:0] count_q,
  input logic          tmo
);
  p_reload_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> reload_q == $past(reload_din));

  p_count_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(reload_q));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && count_q != '1) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

  p_wrap_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> ($past(count_q) == '1 && !$past(cnt_wr)));

  p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> count_q == $past(reload_q));

  p_sel_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 4'b0000 && !cnt_wr) |=> ($stable(count_q) && !tmo));

  p_a_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[3:2] == 2'b00 && !cnt_wr) |=> $stable(count_q));
endmodule

bind gated_reload_timer grt_checker #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reload_wr(reload_wr), .reload_din(reload_din),
  .cnt_wr(cnt_wr), .clk_sel(clk_sel), .reload_q(reload_q),
  .count_q(count_q), .tmo(tmo)
);

// File: tb/gated_reload_timer_tb.sv
module gated_reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reload_din = '0;
  logic        reload_wr = 1'b0, cnt_wr = 1'b0;
  logic [3:0]  clk_sel = '0;
  logic [7:0]  duty_code = 8'd3;
  logic        src_fast = 0, src_ext = 0, src_64hz = 0, src_16hz = 0, src_2hz = 0;
  logic [15:0] reload_q, count_q;
  logic        tmo, pwm_out;

  int n_chk = 0, n_fail = 0, cyc = 0, p64 = 0;
  int m_cnt = 0, m_rel = 0, m_slot = 0;
  bit m_tmo = 0, gen_on = 0, done = 0;

  always #10 clk = ~clk;

  gated_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reload_din(reload_din), .reload_wr(reload_wr),
    .cnt_wr(cnt_wr), .clk_sel(clk_sel), .duty_code(duty_code),
    .src_fast(src_fast), .src_ext(src_ext), .src_64hz(src_64hz),
    .src_16hz(src_16hz), .src_2hz(src_2hz), .reload_q(reload_q),
    .count_q(count_q), .tmo(tmo), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int duty_eff(input int d);
    if (d == 0) return 1;
    if (d == 255) return 254;
    return d;
  endfunction

  // source pulses on coprime periods
  always @(negedge clk) begin
    src_fast = gen_on && (cyc % 3 == 0);
    src_ext  = gen_on && (cyc % 4 == 1);
    src_64hz = gen_on && (cyc % 5 == 2);
    src_16hz = gen_on && (cyc % 7 == 3);
    src_2hz  = gen_on && (cyc % 11 == 4);
  end

  // reference model
  always @(posedge clk) begin
    bit a, b;
    cyc++;
    if (src_64hz) p64++;
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_slot = 0; m_tmo = 0;
    end else begin
      case (clk_sel[3:2])
        2'd0: a = 0;
        2'd1: a = src_fast;
        2'd2: a = src_ext;
        default: a = 1;
      endcase
      case (clk_sel[1:0])
        2'd0: b = (clk_sel != 0);
        2'd1: b = src_64hz;
        2'd2: b = src_16hz;
        default: b = src_2hz;
      endcase
      m_tmo = 0;
      if (cnt_wr) m_cnt = m_rel;
      else if (a && b) begin
        if (m_cnt == 65535) begin
          m_cnt = m_rel; m_tmo = 1; m_slot = (m_slot + 1) % 256;
        end else m_cnt = m_cnt + 1;
      end
      if (reload_wr) m_rel = reload_din;
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(int'(count_q) == m_cnt, "R4 count", count_q, m_cnt);
      chk(tmo == m_tmo, "R5 timeout", tmo, m_tmo);
      chk(int'(reload_q) == m_rel, "R2 reload", reload_q, m_rel);
      chk(int'(pwm_out) == int'(m_slot < duty_eff(duty_code)), "R10 pwm",
          pwm_out, int'(m_slot < duty_eff(duty_code)));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_reload(input logic [15:0] v, input bit load);
    reload_din = v; reload_wr = 1; @(negedge clk);
    reload_wr = 0; cnt_wr = load; @(negedge clk);
    cnt_wr = 0;
  endtask

  task automatic pwm_window(input int n, input int exp, input string tag);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      if (pwm_out) hi++;
    end
    chk(hi == exp, tag, hi, exp);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int c0;
    cycles(3);
    @(posedge clk); #5;
    // R1 reset state
    chk(count_q == 0, "R1 count", count_q, 0);
    chk(reload_q == 0, "R1 reload", reload_q, 0);
    chk(tmo == 0, "R1 tmo", tmo, 0);
    chk(pwm_out == 1, "R1 pwm", pwm_out, 1);
    @(negedge clk);
    rst_n = 1;
    gen_on = 1;

    // R2/R3: load then count every cycle (A=1,B=1) with wraps (R5)
    set_reload(16'hFFF0, 1);
    chk(reload_q == 16'hFFF0, "R2 readback", reload_q, 16'hFFF0);
    clk_sel = 4'b1100;
    cycles(60);

    // R6: code 0000 holds despite pulses
    clk_sel = 4'b0000; @(negedge clk);
    c0 = count_q; cycles(40);
    chk(int'(count_q) == c0, "R6 hold", count_q, c0);

    // R7: input A constant 0 with each B choice
    for (int s = 1; s < 4; s++) begin
      clk_sel = 4'(s); @(negedge clk);
      c0 = count_q; cycles(30);
      chk(int'(count_q) == c0, "R7 hold", count_q, c0);
    end

    // R8: A constant 1, B = 64 Hz pulses alone set the rate
    set_reload(16'h0000, 1);
    clk_sel = 4'b1101;
    c0 = count_q; p64 = 0;
    cycles(220);
    chk(int'(count_q) - c0 == p64, "R8 rate", int'(count_q) - c0, p64);

    // R9: every other A/B pairing, with wraps from a high reload
    set_reload(16'hFFF8, 1);
    for (int s = 4; s < 16; s++) begin
      clk_sel = 4'(s);
      cycles(150);
    end

    // R3 with a same-cycle reload write uses the old value
    reload_din = 16'h1234; reload_wr = 1; cnt_wr = 1; @(negedge clk);
    reload_wr = 0; cnt_wr = 0;
    chk(count_q == 16'hFFF8, "R3 old reload", count_q, 16'hFFF8);

    // R10/R11: timeout every cycle, full 256-slot windows
    clk_sel = 4'b1100;
    set_reload(16'hFFFF, 1);
    duty_code = 8'd3;   pwm_window(256, 3, "R10 duty 3");
    duty_code = 8'd0;   pwm_window(256, 1, "R11 duty 0->1");
    duty_code = 8'd255; pwm_window(256, 254, "R11 duty 255->254");
    duty_code = 8'd254; pwm_window(256, 254, "R11 duty 254");

    // R12: counter write on a wrap cycle suppresses the pulse
    cnt_wr = 1; @(posedge clk); #5;
    chk(tmo == 0, "R12 no pulse", tmo, 0);
    @(negedge clk); cnt_wr = 0;
    cycles(5);

    // R10: timeout every second cycle, 512-cycle period
    set_reload(16'hFFFE, 1);
    duty_code = 8'd128; cycles(3);
    pwm_window(512, 256, "R10 duty 128");
    duty_code = 8'd1; cycles(600);

    finish_run();
  end
endmodule